// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned binary words and a carry-in in purely combinational logic. It is aimed at datapaths where the carry must not ripple bit by bit. The operand width is a parameter. It must be a multiple of four, and the default is sixteen bits.

Every bit first forms a propagate term (the operands differ) and a generate term (both operands are one). It needs no carry to do this. The bits are gathered into four-bit groups. Inside a group, each carry is a flat sum of products over the group's propagates, its generates and the group's incoming carry. Each group also reports whether it would pass a carry straight through (group propagate) and whether it creates a carry of its own that leaves the group (group generate).

A second lookahead level takes these group terms and the external carry-in. With the same flat equations, it forms the carry into every group, the carry-out, and a propagate/generate pair for the whole word. That pair lets the block sit under yet another lookahead level.

Top module: `cla_adder`

## Requirements
- R1: The concatenation {c_out, sum_o} equals a_in + b_in + c_in, treated as unsigned numbers of WIDTH+1 bits, for every input combination.
- R2: blk_prop is 1 exactly when a_in and b_in differ in every bit position, i.e. the bitwise XOR of the operands is all ones. blk_prop and blk_gen are never both 1.
- R3: blk_gen is 1 exactly when a_in + b_in, without the carry-in, is at least 2^WIDTH.
- R4: c_out equals blk_gen OR (blk_prop AND c_in).
- R5: When every bit propagates, the carry-in passes through the whole word. With c_in = 1, sum_o is all zeros and c_out is 1. With c_in = 0, sum_o is all ones and c_out is 0.
- R6: Each four-bit slice k of sum_o (bits 4k+3 down to 4k) equals the low four bits of the slice of a_in plus the slice of b_in plus the carry into that slice. That carry is 1 exactly when the bits below the slice, added with c_in, reach 2^(4k). For k = 0 the carry into the slice is c_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand, unsigned |
| b_in | input | WIDTH | Second operand, unsigned |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |
| blk_prop | output | 1 | Whole-word propagate |
| blk_gen | output | 1 | Whole-word generate |

## Verification
The case that matters most is a carry generated in a low group arriving in the same evaluation as the external carry-in, while the groups above it all propagate. Both sources then feed the same second-level sum of products. The bench provokes this with an exhaustive sweep over operand bits that straddle the first group boundary, with both carry-in values, and with directed patterns that hold the upper groups at all-propagate. Each slice of the sum, the carry-out and the word propagate/generate pair are judged against integer arithmetic computed separately in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int GRP_W = 4;

   typedef struct packed {
      logic prop;
      logic gen;
   } pg_t;

   function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
      pg_t r;
      r.prop = hi.prop & lo.prop;
      r.gen  = hi.gen | (hi.prop & lo.gen);
      return r;
   endfunction
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] p_o,
   output logic [WIDTH-1:0] g_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign p_o[i] = a_in[i] ^ b_in[i];
      assign g_o[i] = a_in[i] & b_in[i];
   end
endmodule

// File: rtl/cla_group4.sv
module cla_group4
   import cla_pkg::*;
(
   input  logic [GRP_W-1:0] p_i,
   input  logic [GRP_W-1:0] g_i,
   input  logic             cin,
   output logic [GRP_W-1:0] c_o,
   output pg_t              grp_o
);
   assign c_o[0] = cin;

   assign c_o[1] = g_i[0]
                 | (p_i[0] & cin);

   assign c_o[2] = g_i[1]
                 | (p_i[1] & g_i[0])
                 | (p_i[1] & p_i[0] & cin);

   assign c_o[3] = g_i[2]
                 | (p_i[2] & g_i[1])
                 | (p_i[2] & p_i[1] & g_i[0])
                 | (p_i[2] & p_i[1] & p_i[0] & cin);

   assign grp_o.prop = p_i[3] & p_i[2] & p_i[1] & p_i[0];

   assign grp_o.gen  = g_i[3]
                     | (p_i[3] & g_i[2])
                     | (p_i[3] & p_i[2] & g_i[1])
                     | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
   import cla_pkg::*;
#(
   parameter int NGRP = 4
) (
   input  pg_t [NGRP-1:0] grp_i,
   input  logic           c0,
   output logic [NGRP:0]  gc_o,
   output pg_t            top_o
);
   assign gc_o[0] = c0;

   // Carry into group k+1 as one flat OR of AND terms: each group j<=k
   // that generates and whose carry crosses groups j+1..k, plus c0
   // crossing groups 0..k.
   for (genvar k = 0; k < NGRP; k++) begin : g_carry
      logic [k+1:0] term;
      for (genvar j = 0; j <= k; j++) begin : g_term
         logic [k:0] fac;
         for (genvar m = 0; m <= k; m++) begin : g_fac
            if (m < j)       assign fac[m] = 1'b1;
            else if (m == j) assign fac[m] = grp_i[m].gen;
            else             assign fac[m] = grp_i[m].prop;
         end
         assign term[j] = &fac;
      end
      logic [k:0] all_p;
      for (genvar m = 0; m <= k; m++) begin : g_allp
         assign all_p[m] = grp_i[m].prop;
      end
      assign term[k+1] = (&all_p) & c0;
      assign gc_o[k+1] = |term;
   end

   // Whole-word propagate/generate, same flat form without c0.
   logic [NGRP-1:0] top_p_fac;
   logic [NGRP-1:0] top_g_term;
   for (genvar j = 0; j < NGRP; j++) begin : g_top
      logic [NGRP-1:0] fac;
      for (genvar m = 0; m < NGRP; m++) begin : g_tfac
         if (m < j)       assign fac[m] = 1'b1;
         else if (m == j) assign fac[m] = grp_i[m].gen;
         else             assign fac[m] = grp_i[m].prop;
      end
      assign top_g_term[j] = &fac;
      assign top_p_fac[j]  = grp_i[j].prop;
   end
   assign top_o.prop = &top_p_fac;
   assign top_o.gen  = |top_g_term;
endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_out,
   output logic             blk_prop,
   output logic             blk_gen
);
   localparam int NGRP = WIDTH / GRP_W;

   if (WIDTH < GRP_W || (WIDTH % GRP_W) != 0) begin : g_bad_width
      $error("cla_adder: WIDTH must be a positive multiple of 4");
   end
   if (NGRP > 16) begin : g_bad_groups
      $error("cla_adder: at most 16 groups in the flat second level");
   end

   logic [WIDTH-1:0] bit_p;
   logic [WIDTH-1:0] bit_g;
   logic [WIDTH-1:0] bit_c;
   pg_t  [NGRP-1:0]  grp_pg;
   logic [NGRP:0]    grp_cin;
   pg_t              top_pg;

   cla_bit_pg #(.WIDTH(WIDTH)) u_pg (
      .a_in (a_in),
      .b_in (b_in),
      .p_o  (bit_p),
      .g_o  (bit_g)
   );

   for (genvar k = 0; k < NGRP; k++) begin : g_grp
      cla_group4 u_grp (
         .p_i   (bit_p[k*GRP_W +: GRP_W]),
         .g_i   (bit_g[k*GRP_W +: GRP_W]),
         .cin   (grp_cin[k]),
         .c_o   (bit_c[k*GRP_W +: GRP_W]),
         .grp_o (grp_pg[k])
      );
   end

   cla_lookahead #(.NGRP(NGRP)) u_la (
      .grp_i (grp_pg),
      .c0    (c_in),
      .gc_o  (grp_cin),
      .top_o (top_pg)
   );

   assign sum_o    = bit_p ^ bit_c;
   assign c_out    = grp_cin[NGRP];
   assign blk_prop = top_pg.prop;
   assign blk_gen  = top_pg.gen;
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk
   import cla_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0]         a_in,
   input logic [WIDTH-1:0]         b_in,
   input logic                     c_in,
   input logic [WIDTH-1:0]         sum_o,
   input logic                     c_out,
   input logic                     blk_prop,
   input logic                     blk_gen,
   input logic [WIDTH/GRP_W:0]     grp_cin,
   input pg_t  [WIDTH/GRP_W-1:0]   grp_pg
);
   localparam int NGRP = WIDTH / GRP_W;

   always_comb begin
      p_total_r1: assert ({c_out, sum_o} ==
                          ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}));
      p_excl_r2: assert (!(blk_prop && blk_gen));
      p_cout_r4: assert (c_out == (blk_gen | (blk_prop & c_in)));
      if (blk_prop) begin
         p_pass_r5: assert (c_out == c_in);
      end
      for (int k = 0; k < NGRP; k++) begin
         p_chain_r6: assert (grp_cin[k+1] ==
                             (grp_pg[k].gen | (grp_pg[k].prop & grp_cin[k])));
      end
   end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a_in     (a_in),
   .b_in     (b_in),
   .c_in     (c_in),
   .sum_o    (sum_o),
   .c_out    (c_out),
   .blk_prop (blk_prop),
   .blk_gen  (blk_gen),
   .grp_cin  (grp_cin),
   .grp_pg   (grp_pg)
);

// File: tb/cla_adder_test.sv
module cla_adder_test;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic         c_in = 1'b0;
   logic [W-1:0] sum_o;
   logic         c_out;
   logic         blk_prop;
   logic         blk_gen;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cla_adder #(.WIDTH(W)) uut (
      .a_in     (a_in),
      .b_in     (b_in),
      .c_in     (c_in),
      .sum_o    (sum_o),
      .c_out    (c_out),
      .blk_prop (blk_prop),
      .blk_gen  (blk_gen)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h cin=%0d actual=%0h expected=%0h",
                  req, a_in, b_in, c_in, act, exp);
      end
   endtask

   // Behavioural reference, evaluated on the applied operands.
   task automatic compare_all();
      longint ua = longint'(a_in);
      longint ub = longint'(b_in);
      longint ci = longint'(c_in);
      longint tot = ua + ub + ci;
      longint full_p = ((ua ^ ub) == ((longint'(1) << W) - 1)) ? 1 : 0;
      longint full_g = ((ua + ub) >= (longint'(1) << W)) ? 1 : 0;
      check("R1", {c_out, sum_o}, tot);
      check("R2", blk_prop, full_p);
      check("R2", blk_prop & blk_gen, 0);
      check("R3", blk_gen, full_g);
      check("R4", c_out, full_g | (full_p & ci));
      for (int k = 0; k < W / 4; k++) begin
         longint msk = (longint'(1) << (4 * k)) - 1;
         longint cin_k = (k == 0) ? ci :
                         ((((ua & msk) + (ub & msk) + ci) > msk) ? 1 : 0);
         longint sa = (ua >> (4 * k)) & 15;
         longint sb = (ub >> (4 * k)) & 15;
         check("R6", (longint'(sum_o) >> (4 * k)) & 15, (sa + sb + cin_k) & 15);
      end
   endtask

   // Apply at a falling edge, judge at the following rising edge.
   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
      @(negedge clk);
      a_in = a;
      b_in = b;
      c_in = c;
      @(posedge clk);
      #0.5;
      compare_all();
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #0.5;
      // Reset state: zero operands give zero everything (R1, R2, R3).
      check("R1", {c_out, sum_o}, 0);
      check("R2", blk_prop, 0);
      check("R3", blk_gen, 0);

      // R5: all-propagate word, carry-in crosses every group.
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R5", {c_out, sum_o}, 17'h10000);
      apply(16'hA5A5, 16'h5A5A, 1'b0);
      check("R5", {c_out, sum_o}, 17'h0FFFF);
      apply(16'h0F0F, 16'hF0F0, 1'b1);
      check("R5", blk_prop, 1);

      // Generate/propagate boundaries.
      apply(16'hFFFF, 16'hFFFF, 1'b0);
      apply(16'h8000, 16'h8000, 1'b0);
      apply(16'hFFFF, 16'h0001, 1'b0);
      apply(16'h000F, 16'h0001, 1'b0);
      apply(16'hFFF0, 16'h0010, 1'b1);

      // Group-0 carry meets carry-in above propagating groups.
      for (int x = 0; x < 64; x++) begin
         for (int y = 0; y < 64; y++) begin
            for (int c = 0; c < 2; c++) begin
               logic [W-1:0] a = W'(x << 2) | 16'h5500;
               logic [W-1:0] b = W'(y << 2) | 16'hAA01;
               apply(a, b, c[0]);
            end
         end
      end

      for (int n = 0; n < 3000; n++) begin
         apply(W'($urandom), W'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule